// File: doc/BRIEF.md
# Timer Interrupt Router with Status Latch

This block is the shared interrupt back end for a bank of timer channels. When a timer signals a fire, the router works out how to deliver it. It can drop the event, emit a message write (an address word and a data word), pulse one line of a 32-line interrupt bus for one cycle, or raise a level on one of those lines and hold it. A held level is latched in a per-timer status bit. That bit suppresses further fires from the same timer until software clears it by writing a one.

Each timer has a configuration word. The word holds an enable bit, a trigger-type bit, a 5-bit route pin and a message-enable bit. Bits 63:32 of the word read back as a fixed allowed-pin mask, and bit 15 reads back as the message capability. If a write names a route pin that is not in the mask, the stored route becomes 0, which means not connected. A configuration write can leave a latched level interrupt with nowhere valid to go. When it does, the router releases that interrupt so that no line stays asserted forever.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset every status bit, interrupt line, pulse line and message strobe is 0. A timer's configuration reads back as 64'hFF00_0000_0000_8000: the allowed mask in bits 63:32, the capability in bit 15, and every writable field 0.
- R2: A fire is dropped with no visible effect while the timer's enable bit (config bit 2) is 0.
- R3: With config bit 1 = 0 (edge), message delivery off and route pin p != 0, a fire drives irq_pulse[p] high for exactly the one cycle after the fire is sampled. It sets no status bit.
- R4: With config bit 1 = 1 (level), message delivery off and route pin p != 0, a fire sets the timer's status bit and holds irq_level[p] high until that bit is cleared.
- R5: A fire on a timer whose status bit is already set is dropped and is not remembered: once the bit is cleared, no interrupt reappears.
- R6: A status write clears exactly the bits that are written 1 and are currently set, and drops their lines. Bits written 0 are unchanged.
- R7: When the capability and config bit 14 are both set, a fire produces one cycle of msg_valid. msg_addr carries bits 63:32 of the timer's message word and msg_data carries bits 31:0. No line, pulse or status bit changes.
- R8: The route pin is config bits 13:9. Pin 0 delivers nothing on any line.
- R9: A configuration write whose route pin is nonzero and not set in the allowed mask stores route 0. An allowed pin is stored as written.
- R10: A set status bit is cleared, and its line dropped, by a configuration write that disables the timer, selects message delivery, selects edge type or changes the route pin. A write that changes none of these leaves the bit set.
- R11: irq_level[p] is the OR over every timer that has a set status bit and is routed to pin p.
- R12: Message fires that arrive together are delivered one per cycle, the lowest timer index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire | input | NUM_TIMERS | One bit per timer, high for each cycle the timer fires |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | IDX_W | Timer addressed by the configuration write |
| cfg_wr_data | input | 64 | Configuration word to write |
| msg_wr_en | input | 1 | Message word write strobe |
| msg_wr_idx | input | IDX_W | Timer addressed by the message word write |
| msg_wr_data | input | 64 | Message address (63:32) and data (31:0) |
| sts_wr_en | input | 1 | Status write-one-to-clear strobe |
| sts_wr_data | input | NUM_TIMERS | Status bits to clear |
| cfg_rd_idx | input | IDX_W | Timer whose configuration is read back |
| cfg_rd_data | output | 64 | Configuration readback |
| sts | output | NUM_TIMERS | Interrupt status bits |
| irq_level | output | NUM_PINS | Level interrupt lines |
| irq_pulse | output | NUM_PINS | One-cycle edge interrupt pulses |
| msg_valid | output | 1 | Message write strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench fires a level timer again while its status bit is set and then clears the bit. A design that queued the second fire would raise the line again. The bench rewrites a level configuration that is unchanged and then rewrites it with a moved pin, disabled, switched to edge and switched to message delivery. A design with the release logic wrong would either drop the interrupt on the harmless write or keep a stranded line high. Two level timers share one pin, to catch a design that lets the last writer own the line instead of ORing the sources. Two message timers fire in the same cycle, to catch a design that loses one of them or delivers them out of index order. Route writes outside the allowed mask must read back as 0, and a status write of 0 must change nothing.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  localparam int ROUTE_W     = 5;
  localparam int ROUTE_LSB   = 9;
  localparam int LEVEL_BIT   = 1;
  localparam int ENABLE_BIT  = 2;
  localparam int MSG_EN_BIT  = 14;
  localparam int MSG_CAP_BIT = 15;

  typedef struct packed {
    logic               msg_en;
    logic [ROUTE_W-1:0] route;
    logic               enable;
    logic               level;
  } chan_cfg_t;

  // Keep only writable fields; a route outside the allowed mask becomes 0
  function automatic chan_cfg_t cfg_decode(input logic [63:0] word,
                                           input logic [31:0] allowed);
    chan_cfg_t c;
    c.msg_en = word[MSG_EN_BIT];
    c.route  = word[ROUTE_LSB +: ROUTE_W];
    c.enable = word[ENABLE_BIT];
    c.level  = word[LEVEL_BIT];
    if (c.route != '0 && !allowed[c.route]) c.route = '0;
    return c;
  endfunction

  function automatic logic [63:0] cfg_encode(input chan_cfg_t c,
                                             input logic [31:0] allowed,
                                             input logic cap);
    logic [63:0] w;
    w = '0;
    w[63:32] = allowed;
    w[MSG_CAP_BIT] = cap;
    w[MSG_EN_BIT] = c.msg_en;
    w[ROUTE_LSB +: ROUTE_W] = c.route;
    w[ENABLE_BIT] = c.enable;
    w[LEVEL_BIT] = c.level;
    return w;
  endfunction

endpackage

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan
  import tmr_irq_pkg::*;
#(
  parameter logic [31:0] ALLOWED_IRQ = 32'hFF00_0000,
  parameter logic        MSG_CAP     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [63:0]        cfg_wdata,
  input  logic               msg_we,
  input  logic [63:0]        msg_wdata,
  input  logic               sts_clr,
  input  logic               fire,
  output chan_cfg_t          cfg_q,
  output logic               sts_q,
  output logic [ROUTE_W-1:0] eff_pin,
  output logic               edge_hit,
  output logic               msg_hit,
  output logic               msg_mode,
  output logic [63:0]        msg_word
);

  chan_cfg_t    cfg_d, cfg_new;
  logic         sts_d;
  logic [63:0]  msg_d;
  logic         fire_ok, line_ok, lvl_set, new_msg, release_now;

  always_comb begin
    msg_mode = MSG_CAP & cfg_q.msg_en;
    eff_pin  = msg_mode ? '0 : cfg_q.route;

    // fire decision uses the configuration in force before any write this cycle
    fire_ok  = fire & cfg_q.enable & ~sts_q;
    line_ok  = fire_ok & ~msg_mode & (eff_pin != '0);
    msg_hit  = fire_ok & msg_mode;
    edge_hit = line_ok & ~cfg_q.level;
    lvl_set  = line_ok & cfg_q.level;

    cfg_new = cfg_decode(cfg_wdata, ALLOWED_IRQ);
    new_msg = MSG_CAP & cfg_new.msg_en;
    release_now = cfg_we & (~cfg_new.enable | new_msg | ~cfg_new.level |
                            (cfg_new.route != cfg_q.route));

    cfg_d = cfg_we ? cfg_new : cfg_q;
    sts_d = (lvl_set | (sts_q & ~sts_clr)) & ~release_now;
    msg_d = msg_we ? msg_wdata : msg_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      sts_q    <= 1'b0;
      msg_word <= '0;
    end else begin
      cfg_q    <= cfg_d;
      sts_q    <= sts_d;
      msg_word <= msg_d;
    end
  end

endmodule

// File: rtl/tmr_irq_msg_arb.sv
module tmr_irq_msg_arb #(
  parameter int NUM_TIMERS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_TIMERS-1:0]      new_req,
  input  logic [NUM_TIMERS-1:0]      keep_ok,
  input  logic [NUM_TIMERS-1:0][63:0] words,
  output logic                       msg_valid,
  output logic [31:0]                msg_addr,
  output logic [31:0]                msg_data
);

  logic [NUM_TIMERS-1:0] pend_q, pend_d, req, grant;
  logic [63:0]           sel_word;
  logic                  valid_d;

  always_comb begin
    req   = pend_q | new_req;
    grant = req & (~req + 1'b1);
    sel_word = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (grant[i]) sel_word = sel_word | words[i];
    end
    valid_d = |req;
    pend_d  = req & ~grant & keep_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend_q    <= pend_d;
      msg_valid <= valid_d;
      if (valid_d) begin
        msg_addr <= sel_word[63:32];
        msg_data <= sel_word[31:0];
      end
    end
  end

endmodule

// File: rtl/tmr_irq_pin_merge.sv
module tmr_irq_pin_merge #(
  parameter int NUM_TIMERS = 8,
  parameter int NUM_PINS   = 32,
  parameter int ROUTE_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_TIMERS-1:0][ROUTE_W-1:0] eff_pin,
  input  logic [NUM_TIMERS-1:0]             sts_q,
  input  logic [NUM_TIMERS-1:0]             edge_hit,
  output logic [NUM_PINS-1:0]               irq_level,
  output logic [NUM_PINS-1:0]               irq_pulse
);

  logic [NUM_PINS-1:0] pulse_d;

  // pin 0 means not connected and is never driven
  assign irq_level[0] = 1'b0;
  assign pulse_d[0]   = 1'b0;

  for (genvar p = 1; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      irq_level[p] = 1'b0;
      pulse_d[p]   = 1'b0;
      for (int t = 0; t < NUM_TIMERS; t++) begin
        if (eff_pin[t] == ROUTE_W'(p)) begin
          irq_level[p] = irq_level[p] | sts_q[t];
          pulse_d[p]   = pulse_d[p] | edge_hit[t];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= '0;
    else        irq_pulse <= pulse_d;
  end

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int          NUM_TIMERS  = 8,
  parameter int          NUM_PINS    = 32,
  parameter logic [31:0] ALLOWED_IRQ = 32'hFF00_0000,
  parameter logic        MSG_CAP     = 1'b1,
  localparam int         IDX_W       = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TIMERS-1:0] fire,
  input  logic                  cfg_wr_en,
  input  logic [IDX_W-1:0]      cfg_wr_idx,
  input  logic [63:0]           cfg_wr_data,
  input  logic                  msg_wr_en,
  input  logic [IDX_W-1:0]      msg_wr_idx,
  input  logic [63:0]           msg_wr_data,
  input  logic                  sts_wr_en,
  input  logic [NUM_TIMERS-1:0] sts_wr_data,
  input  logic [IDX_W-1:0]      cfg_rd_idx,
  output logic [63:0]           cfg_rd_data,
  output logic [NUM_TIMERS-1:0] sts,
  output logic [NUM_PINS-1:0]   irq_level,
  output logic [NUM_PINS-1:0]   irq_pulse,
  output logic                  msg_valid,
  output logic [31:0]           msg_addr,
  output logic [31:0]           msg_data
);

  chan_cfg_t [NUM_TIMERS-1:0]              cfg_q;
  logic [NUM_TIMERS-1:0][ROUTE_W-1:0]      eff_pin;
  logic [NUM_TIMERS-1:0]                   edge_hit, msg_hit, msg_mode, keep_ok;
  logic [NUM_TIMERS-1:0][63:0]             msg_word;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chan
    tmr_irq_chan #(.ALLOWED_IRQ(ALLOWED_IRQ), .MSG_CAP(MSG_CAP)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_wr_en && (cfg_wr_idx == IDX_W'(t))),
      .cfg_wdata(cfg_wr_data),
      .msg_we   (msg_wr_en && (msg_wr_idx == IDX_W'(t))),
      .msg_wdata(msg_wr_data),
      .sts_clr  (sts_wr_en & sts_wr_data[t]),
      .fire     (fire[t]),
      .cfg_q    (cfg_q[t]),
      .sts_q    (sts[t]),
      .eff_pin  (eff_pin[t]),
      .edge_hit (edge_hit[t]),
      .msg_hit  (msg_hit[t]),
      .msg_mode (msg_mode[t]),
      .msg_word (msg_word[t])
    );
    assign keep_ok[t] = msg_mode[t] & cfg_q[t].enable;
  end

  assign cfg_rd_data = cfg_encode(cfg_q[cfg_rd_idx], ALLOWED_IRQ, MSG_CAP);

  tmr_irq_msg_arb #(.NUM_TIMERS(NUM_TIMERS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_req  (msg_hit),
    .keep_ok  (keep_ok),
    .words    (msg_word),
    .msg_valid(msg_valid),
    .msg_addr (msg_addr),
    .msg_data (msg_data)
  );

  tmr_irq_pin_merge #(.NUM_TIMERS(NUM_TIMERS), .NUM_PINS(NUM_PINS), .ROUTE_W(ROUTE_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .eff_pin  (eff_pin),
    .sts_q    (sts),
    .edge_hit (edge_hit),
    .irq_level(irq_level),
    .irq_pulse(irq_pulse)
  );

endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk #(
  parameter int NUM_TIMERS = 8,
  parameter int NUM_PINS   = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_TIMERS-1:0] fire,
  input logic                  cfg_wr_en,
  input logic                  sts_wr_en,
  input logic [NUM_TIMERS-1:0] sts_wr_data,
  input logic [NUM_TIMERS-1:0] sts,
  input logic [NUM_PINS-1:0]   irq_level,
  input logic [NUM_PINS-1:0]   irq_pulse
);

  AST_STS_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts) & ~$past(fire)) == '0)); // R4

  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr_en |=> ((sts & $past(sts_wr_data & sts)) == '0)); // R6

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0 && !sts_wr_en && !cfg_wr_en) |=> $stable(sts)); // R5

  AST_PULSE_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> $past(|fire)); // R3

  AST_LEVEL_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_level) |-> (|sts)); // R11

endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NUM_TIMERS(NUM_TIMERS), .NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fire       (fire),
  .cfg_wr_en  (cfg_wr_en),
  .sts_wr_en  (sts_wr_en),
  .sts_wr_data(sts_wr_data),
  .sts        (sts),
  .irq_level  (irq_level),
  .irq_pulse  (irq_pulse)
);

// File: tb/sim_tmr_irq_router.sv
`timescale 1ns/1ps
module sim_tmr_irq_router;

  localparam int N = 8;
  localparam int P = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  fire = '0;
  logic          cfg_wr_en = 1'b0;
  logic [IW-1:0] cfg_wr_idx = '0;
  logic [63:0]   cfg_wr_data = '0;
  logic          msg_wr_en = 1'b0;
  logic [IW-1:0] msg_wr_idx = '0;
  logic [63:0]   msg_wr_data = '0;
  logic          sts_wr_en = 1'b0;
  logic [N-1:0]  sts_wr_data = '0;
  logic [IW-1:0] cfg_rd_idx = '0;
  logic [63:0]   cfg_rd_data;
  logic [N-1:0]  sts;
  logic [P-1:0]  irq_level, irq_pulse;
  logic          msg_valid;
  logic [31:0]   msg_addr, msg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .msg_wr_en(msg_wr_en), .msg_wr_idx(msg_wr_idx), .msg_wr_data(msg_wr_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data), .sts(sts),
    .irq_level(irq_level), .irq_pulse(irq_pulse),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [63:0] mk(bit en, bit lvl, int pin, bit msg);
    return (64'(en) << 2) | (64'(lvl) << 1) | (64'(pin & 31) << 9) | (64'(msg) << 14);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cfg(int idx, logic [63:0] d);
    cfg_wr_en = 1'b1; cfg_wr_idx = IW'(idx); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wr_msg(int idx, logic [63:0] d);
    msg_wr_en = 1'b1; msg_wr_idx = IW'(idx); msg_wr_data = d;
    @(negedge clk);
    msg_wr_en = 1'b0;
  endtask

  task automatic do_fire(logic [N-1:0] m);
    fire = m;
    @(negedge clk);
    fire = '0;
  endtask

  task automatic do_clr(logic [N-1:0] m);
    sts_wr_en = 1'b1; sts_wr_data = m;
    @(negedge clk);
    sts_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    cfg_rd_idx = 3'd0;
    #1;
    chk("R1 sts", 64'(sts), 64'h0);
    chk("R1 level", 64'(irq_level), 64'h0);
    chk("R1 pulse", 64'(irq_pulse), 64'h0);
    chk("R1 msg_valid", 64'(msg_valid), 64'h0);
    chk("R1 cfg readback", cfg_rd_data, 64'hFF00_0000_0000_8000);
  endtask

  task automatic t_disabled;
    wr_cfg(0, mk(0, 1, 24, 0));
    do_fire(8'h01);
    chk("R2 sts", 64'(sts), 64'h0);
    chk("R2 level", 64'(irq_level), 64'h0);
    chk("R2 pulse", 64'(irq_pulse), 64'h0);
  endtask

  task automatic t_edge;
    wr_cfg(1, mk(1, 0, 25, 0));
    do_fire(8'h02);
    chk("R3 pulse", 64'(irq_pulse), 64'(32'h1 << 25));
    chk("R3 sts", 64'(sts), 64'h0);
    cyc(1);
    chk("R3 pulse width", 64'(irq_pulse), 64'h0);
  endtask

  task automatic t_level;
    wr_cfg(2, mk(1, 1, 26, 0));
    do_fire(8'h04);
    chk("R4 sts", 64'(sts), 64'h04);
    chk("R4 level", 64'(irq_level), 64'(32'h1 << 26));
    cyc(3);
    chk("R4 held", 64'(irq_level), 64'(32'h1 << 26));
    do_fire(8'h04);
    chk("R5 refire", 64'(sts), 64'h04);
    do_clr(8'h00);
    chk("R6 zero write", 64'(sts), 64'h04);
    do_clr(8'h04);
    chk("R6 cleared", 64'(sts), 64'h0);
    chk("R6 line drop", 64'(irq_level), 64'h0);
    cyc(2);
    chk("R5 not queued", 64'(irq_level), 64'h0);
  endtask

  task automatic t_pin0;
    wr_cfg(3, mk(1, 0, 0, 0));
    do_fire(8'h08);
    chk("R8 edge pin0", 64'(irq_pulse), 64'h0);
    wr_cfg(3, mk(1, 1, 0, 0));
    do_fire(8'h08);
    chk("R8 level pin0 sts", 64'(sts), 64'h0);
    chk("R8 level pin0 line", 64'(irq_level), 64'h0);
  endtask

  task automatic t_snap;
    cfg_rd_idx = 3'd4;
    wr_cfg(4, mk(1, 1, 5, 0));
    chk("R9 snapped", 64'(cfg_rd_data[13:9]), 64'd0);
    wr_cfg(4, mk(1, 1, 27, 0));
    chk("R9 allowed", 64'(cfg_rd_data[13:9]), 64'd27);
    do_fire(8'h10);
    chk("R9 allowed delivers", 64'(irq_level), 64'(32'h1 << 27));
    do_clr(8'h10);
  endtask

  task automatic t_msg;
    wr_msg(5, 64'hFEE0_1000_0000_0041);
    wr_cfg(5, mk(1, 1, 28, 1));
    do_fire(8'h20);
    chk("R7 valid", 64'(msg_valid), 64'h1);
    chk("R7 addr", 64'(msg_addr), 64'hFEE0_1000);
    chk("R7 data", 64'(msg_data), 64'h0000_0041);
    chk("R7 no line", 64'(irq_level | irq_pulse), 64'h0);
    chk("R7 no sts", 64'(sts), 64'h0);
    cyc(1);
    chk("R7 one cycle", 64'(msg_valid), 64'h0);
  endtask

  task automatic t_arb;
    wr_msg(6, 64'hFEE0_2000_0000_0052);
    wr_cfg(6, mk(1, 0, 0, 1));
    do_fire(8'h60);
    chk("R12 first valid", 64'(msg_valid), 64'h1);
    chk("R12 first data", 64'(msg_data), 64'h41);
    cyc(1);
    chk("R12 second valid", 64'(msg_valid), 64'h1);
    chk("R12 second addr", 64'(msg_addr), 64'hFEE0_2000);
    chk("R12 second data", 64'(msg_data), 64'h52);
    cyc(1);
    chk("R12 drained", 64'(msg_valid), 64'h0);
  endtask

  task automatic t_stale;
    wr_cfg(2, mk(1, 1, 26, 0));
    do_fire(8'h04);
    wr_cfg(2, mk(1, 1, 26, 0));
    chk("R10 same cfg keeps", 64'(sts), 64'h04);
    wr_cfg(2, mk(1, 1, 27, 0));
    chk("R10 pin change", 64'(sts), 64'h0);
    chk("R10 pin change line", 64'(irq_level), 64'h0);
    wr_cfg(2, mk(1, 1, 26, 0));
    do_fire(8'h04);
    wr_cfg(2, mk(0, 1, 26, 0));
    chk("R10 disable", 64'(sts), 64'h0);
    wr_cfg(2, mk(1, 1, 26, 0));
    do_fire(8'h04);
    wr_cfg(2, mk(1, 0, 26, 0));
    chk("R10 edge", 64'(sts), 64'h0);
    wr_cfg(2, mk(1, 1, 26, 0));
    do_fire(8'h04);
    wr_cfg(2, mk(1, 1, 26, 1));
    chk("R10 msg", 64'(sts), 64'h0);
    chk("R10 msg line", 64'(irq_level), 64'h0);
    cyc(1);
  endtask

  task automatic t_or;
    wr_cfg(2, mk(1, 1, 29, 0));
    wr_cfg(7, mk(1, 1, 29, 0));
    do_fire(8'h84);
    chk("R11 both", 64'(irq_level), 64'(32'h1 << 29));
    do_clr(8'h04);
    chk("R11 one left", 64'(irq_level), 64'(32'h1 << 29));
    do_clr(8'h80);
    chk("R11 none", 64'(irq_level), 64'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_disabled();
    t_edge();
    t_level();
    t_pin0();
    t_snap();
    t_msg();
    t_arb();
    t_stale();
    t_or();
    cyc(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule